// File: doc/BRIEF.md
# Pixel Object Priority and Colour Select

On every pixel clock this block takes the serial bits of six screen objects and produces one colour code. The objects are two players, a missile for each player, a ball and the playfield. The objects are gathered into three groups, each with one colour register:

- the player 0 group (player 0 and missile 0);
- the player 1 group (player 1 and missile 1);
- the field group (playfield and ball).

A fourth register holds the background colour. A fixed ordering decides which group is shown where objects overlap. A field-first control bit lifts the field group above both player groups.

A score control bit recolours the bare playfield: it takes the player 0 colour on the left half of the line and the player 1 colour on the right half. The ball is not recoloured. The block keeps the four 7-bit colour registers, which are written through a simple write port. The chosen register drives a registered output, split into a 4-bit hue and a 3-bit luminance. A one-hot register-select vector comes out beside it. During blanking the output is held at zero.

Top module: `pixel_prio_mux`

## Requirements
- R1: While rst_n is low, hue_o, lum_o and sel_o are all zero and every colour register is cleared to zero.
- R2: A cycle with wr_en high loads wr_data into the register named by wr_addr. The addresses are 0 background, 1 player 0, 2 player 1 and 3 field. Bits [6:3] of wr_data hold the hue and bits [2:0] hold the luminance. The new value is used for pixels presented from the next cycle onward.
- R3: Every output is registered. Pixel inputs presented in one cycle appear on hue_o, lum_o and sel_o after the next rising clock edge.
- R4: With field_first low, the groups are ranked as follows, highest first: player 0, player 1, field, background.
- R5: A missile takes the colour and rank of its own player. The ball takes the colour and rank of the field group.
- R6: With field_first high, the groups are ranked as follows, highest first: field, player 0, player 1, background.
- R7: With score_mode high, when the field group wins and the ball is not set, the player 0 register is used when right_half is 0 and the player 1 register when right_half is 1.
- R8: In score mode, a field-group win with the ball set uses the field register. The group ranking does not change in score mode.
- R9: The background register is chosen only when none of the six object bits is set.
- R10: With blank high, the next hue_o, lum_o and sel_o are zero whatever the other inputs are.
- R11: Outside blanking, sel_o is one-hot and names the register whose value is output. Bit 0 is background, bit 1 is player 0, bit 2 is player 1 and bit 3 is field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank | input | 1 | Blanking interval, forces zero output |
| right_half | input | 1 | 1 on the right half of the line |
| field_first | input | 1 | Field group ranked above the players |
| score_mode | input | 1 | Colour the playfield with the player colours by half |
| p0_bit | input | 1 | Player 0 serial bit |
| m0_bit | input | 1 | Missile 0 serial bit |
| p1_bit | input | 1 | Player 1 serial bit |
| m1_bit | input | 1 | Missile 1 serial bit |
| ball_bit | input | 1 | Ball serial bit |
| pf_bit | input | 1 | Playfield serial bit |
| wr_en | input | 1 | Colour register write strobe |
| wr_addr | input | 2 | Colour register index |
| wr_data | input | 7 | Hue in [6:3], luminance in [2:0] |
| hue_o | output | 4 | Selected hue |
| lum_o | output | 3 | Selected luminance |
| sel_o | output | 4 | One-hot register select |

## Verification
The bench targets overlaps where the ranking matters:

- A missile alone against the other player's group, which exposes a design that ranks single objects instead of pairs.
- The ball against a player with the field-first bit set, which exposes a missed rank change.
- A bare playfield in score mode on each half. A design that mixes up the halves shows the wrong player colour, and one that also recolours the ball gives the ball a player colour.

A write and a pixel in back-to-back cycles shows whether the new colour arrives one pixel early or late. Blank combined with every object set shows whether the zero forcing can leak a colour.

// File: rtl/pixel_prio_pkg.sv
package pixel_prio_pkg;

    localparam int NUM_REGS = 4;
    localparam int RID_W    = $clog2(NUM_REGS);

    typedef enum logic [RID_W-1:0] {
        RID_BACK = 2'd0,
        RID_PL0  = 2'd1,
        RID_PL1  = 2'd2,
        RID_FLD  = 2'd3
    } reg_id_e;

    typedef struct packed {
        logic p0;
        logic m0;
        logic p1;
        logic m1;
        logic ball;
        logic pf;
    } obj_bits_t;

    typedef struct packed {
        logic field_first;
        logic score_mode;
        logic right_half;
    } mode_t;

endpackage

// File: rtl/pixel_colour_regs.sv
module pixel_colour_regs
    import pixel_prio_pkg::*;
#(
    parameter int COL_W = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [RID_W-1:0]          wr_addr,
    input  logic [COL_W-1:0]          wr_data,
    output logic [NUM_REGS*COL_W-1:0] regs_flat
);

    typedef struct packed {
        logic [NUM_REGS-1:0][COL_W-1:0] val;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (wr_addr == RID_W'(i))) begin
                bank_d.val[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
            assign regs_flat[g*COL_W +: COL_W] = bank_q.val[g];
        end
    endgenerate

endmodule

// File: rtl/pixel_prio_resolve.sv
module pixel_prio_resolve
    import pixel_prio_pkg::*;
(
    input  obj_bits_t           objs,
    input  mode_t               mode,
    output logic [NUM_REGS-1:0] sel
);

    logic    grp_pl0, grp_pl1, grp_fld;
    reg_id_e winner;
    reg_id_e chosen;

    always_comb begin
        grp_pl0 = objs.p0 | objs.m0;
        grp_pl1 = objs.p1 | objs.m1;
        grp_fld = objs.pf | objs.ball;

        if (mode.field_first) begin
            if      (grp_fld) winner = RID_FLD;
            else if (grp_pl0) winner = RID_PL0;
            else if (grp_pl1) winner = RID_PL1;
            else              winner = RID_BACK;
        end else begin
            if      (grp_pl0) winner = RID_PL0;
            else if (grp_pl1) winner = RID_PL1;
            else if (grp_fld) winner = RID_FLD;
            else              winner = RID_BACK;
        end

        chosen = winner;
        if (winner == RID_FLD && mode.score_mode && !objs.ball) begin
            chosen = mode.right_half ? RID_PL1 : RID_PL0;
        end

        sel = '0;
        sel[chosen] = 1'b1;
    end

endmodule

// File: rtl/pixel_colour_mux.sv
module pixel_colour_mux
    import pixel_prio_pkg::*;
#(
    parameter int COL_W = 7
) (
    input  logic [NUM_REGS-1:0]       sel,
    input  logic [NUM_REGS*COL_W-1:0] regs_flat,
    output logic [COL_W-1:0]          colour
);

    logic [NUM_REGS-1:0][COL_W-1:0] gated;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_gate
            assign gated[g] = regs_flat[g*COL_W +: COL_W] & {COL_W{sel[g]}};
        end
    endgenerate

    always_comb begin
        colour = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            colour = colour | gated[i];
        end
    end

endmodule

// File: rtl/pixel_prio_mux.sv
module pixel_prio_mux
    import pixel_prio_pkg::*;
#(
    parameter int HUE_W = 4,
    parameter int LUM_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blank,
    input  logic                   right_half,
    input  logic                   field_first,
    input  logic                   score_mode,
    input  logic                   p0_bit,
    input  logic                   m0_bit,
    input  logic                   p1_bit,
    input  logic                   m1_bit,
    input  logic                   ball_bit,
    input  logic                   pf_bit,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [HUE_W+LUM_W-1:0] wr_data,
    output logic [HUE_W-1:0]       hue_o,
    output logic [LUM_W-1:0]       lum_o,
    output logic [3:0]             sel_o
);

    localparam int COL_W = HUE_W + LUM_W;

    typedef struct packed {
        logic [NUM_REGS-1:0] sel;
        logic [COL_W-1:0]    colour;
    } out_t;

    obj_bits_t                 objs;
    mode_t                     mode;
    logic [NUM_REGS*COL_W-1:0] regs_flat;
    logic [NUM_REGS-1:0]       sel_raw;
    logic [COL_W-1:0]          colour_raw;
    out_t                      out_d, out_q;

    assign objs = '{p0: p0_bit, m0: m0_bit, p1: p1_bit, m1: m1_bit,
                    ball: ball_bit, pf: pf_bit};
    assign mode = '{field_first: field_first, score_mode: score_mode,
                    right_half: right_half};

    pixel_colour_regs #(.COL_W(COL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    pixel_prio_resolve u_resolve (
        .objs (objs),
        .mode (mode),
        .sel  (sel_raw)
    );

    pixel_colour_mux #(.COL_W(COL_W)) u_mux (
        .sel       (sel_raw),
        .regs_flat (regs_flat),
        .colour    (colour_raw)
    );

    always_comb begin
        out_d = out_q;
        if (blank) begin
            out_d = '0;
        end else begin
            out_d.sel    = sel_raw;
            out_d.colour = colour_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign hue_o = out_q.colour[COL_W-1:LUM_W];
    assign lum_o = out_q.colour[LUM_W-1:0];
    assign sel_o = out_q.sel;

endmodule

// File: rtl/pixel_prio_checker.sv
module pixel_prio_checker #(
    parameter int HUE_W = 4,
    parameter int LUM_W = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           blank,
    input logic                           field_first,
    input logic                           p0_bit,
    input logic                           m0_bit,
    input logic                           p1_bit,
    input logic                           m1_bit,
    input logic                           ball_bit,
    input logic                           pf_bit,
    input logic                           wr_en,
    input logic [1:0]                     wr_addr,
    input logic [HUE_W+LUM_W-1:0]         wr_data,
    input logic [HUE_W-1:0]               hue_o,
    input logic [LUM_W-1:0]               lum_o,
    input logic [3:0]                     sel_o,
    input logic [4*(HUE_W+LUM_W)-1:0]     regs_flat
);

    localparam int COL_W = HUE_W + LUM_W;

    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_sel_onehot0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    assert_sel_one_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !blank |=> $countones(sel_o) == 1);

    assert_blank_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && blank |=> (sel_o == 4'd0 && hue_o == '0 && lum_o == '0));

    assert_back_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !blank && (p0_bit | m0_bit | p1_bit | m1_bit | ball_bit | pf_bit)
        |=> !sel_o[0]);

    assert_pl0_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !blank && !field_first && (p0_bit | m0_bit) |=> sel_o == 4'b0010);

    assert_ball_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !blank && field_first && ball_bit |=> sel_o == 4'b1000);

    assert_reg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && wr_en |=> regs_flat[$past(wr_addr)*COL_W +: COL_W] == $past(wr_data));

endmodule

bind pixel_prio_mux pixel_prio_checker #(.HUE_W(HUE_W), .LUM_W(LUM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .blank       (blank),
    .field_first (field_first),
    .p0_bit      (p0_bit),
    .m0_bit      (m0_bit),
    .p1_bit      (p1_bit),
    .m1_bit      (m1_bit),
    .ball_bit    (ball_bit),
    .pf_bit      (pf_bit),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .hue_o       (hue_o),
    .lum_o       (lum_o),
    .sel_o       (sel_o),
    .regs_flat   (regs_flat)
);

// File: tb/sim_pixel_prio_mux.sv
`timescale 1ns/1ps
module sim_pixel_prio_mux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blank = 1'b0, right_half = 1'b0, field_first = 1'b0, score_mode = 1'b0;
    logic       p0_bit = 1'b0, m0_bit = 1'b0, p1_bit = 1'b0, m1_bit = 1'b0;
    logic       ball_bit = 1'b0, pf_bit = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [6:0] wr_data = 7'd0;
    logic [3:0] hue_o;
    logic [2:0] lum_o;
    logic [3:0] sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [6:0] mdl [4];

    always #5 clk = ~clk;

    pixel_prio_mux u0 (
        .clk(clk), .rst_n(rst_n), .blank(blank), .right_half(right_half),
        .field_first(field_first), .score_mode(score_mode),
        .p0_bit(p0_bit), .m0_bit(m0_bit), .p1_bit(p1_bit), .m1_bit(m1_bit),
        .ball_bit(ball_bit), .pf_bit(pf_bit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hue_o(hue_o), .lum_o(lum_o), .sel_o(sel_o)
    );

    // objs order: {p0,m0,p1,m1,ball,pf}; result is the register index
    function automatic int pick(input logic [5:0] o, input logic ff,
                                input logic sc, input logic rh);
        logic g0, g1, gf;
        int w;
        g0 = o[5] | o[4];
        g1 = o[3] | o[2];
        gf = o[1] | o[0];
        if (ff) w = gf ? 3 : g0 ? 1 : g1 ? 2 : 0;
        else    w = g0 ? 1 : g1 ? 2 : gf ? 3 : 0;
        if (w == 3 && sc && !o[1]) w = rh ? 2 : 1;
        return w;
    endfunction

    task automatic compare(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual sel=%b col=%h expected sel=%b col=%h",
                     req, act[13:7], act[6:0], exp[13:7], exp[6:0]);
        end
    endtask

    // one pixel: drive, clock, check, then commit any write to the model
    task automatic pixel(input string req, input logic [5:0] o, input logic bl,
                         input logic ff, input logic sc, input logic rh,
                         input logic we, input logic [1:0] wa, input logic [6:0] wd);
        int w;
        logic [13:0] exp;
        {p0_bit, m0_bit, p1_bit, m1_bit, ball_bit, pf_bit} = o;
        blank = bl; field_first = ff; score_mode = sc; right_half = rh;
        wr_en = we; wr_addr = wa; wr_data = wd;
        w = pick(o, ff, sc, rh);
        if (bl) exp = '0;
        else    exp = {7'(4'b1 << w), mdl[w]};
        @(posedge clk);
        #2;
        compare(req, {3'b0, sel_o, hue_o, lum_o}, exp);
        if (we) mdl[wa] = wd;
        @(negedge clk);
    endtask

    task automatic load(input logic [1:0] a, input logic [6:0] d);
        pixel("R2", 6'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h2c4b));
        for (int i = 0; i < 4; i++) mdl[i] = 7'd0;
        {p0_bit, pf_bit, ball_bit} = 3'b111;
        repeat (3) @(posedge clk);
        #2;
        compare("R1 reset", {3'b0, sel_o, hue_o, lum_o}, 14'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: distinct register values
        load(2'd0, 7'h11);
        load(2'd1, 7'h2a);
        load(2'd2, 7'h4c);
        load(2'd3, 7'h75);

        pixel("R9 background",        6'b000000, 0, 0, 0, 0, 0, 0, 0);
        pixel("R4 p0 over p1 and pf", 6'b101001, 0, 0, 0, 0, 0, 0, 0);
        pixel("R5 m0 over p1",        6'b011000, 0, 0, 0, 0, 0, 0, 0);
        pixel("R5 m1 over pf",        6'b000101, 0, 0, 0, 0, 0, 0, 0);
        pixel("R5 ball field colour", 6'b000010, 0, 0, 0, 0, 0, 0, 0);
        pixel("R6 ball over p0",      6'b100010, 0, 1, 0, 0, 0, 0, 0);
        pixel("R6 p0 over m1",        6'b100100, 0, 1, 0, 0, 0, 0, 0);
        pixel("R7 score left",        6'b000001, 0, 0, 1, 0, 0, 0, 0);
        pixel("R7 score right",       6'b000001, 0, 0, 1, 1, 0, 0, 0);
        pixel("R8 score ball",        6'b000011, 0, 0, 1, 1, 0, 0, 0);
        pixel("R8 score rank kept",   6'b000101, 0, 0, 1, 0, 0, 0, 0);
        pixel("R10 blank all on",     6'b111111, 1, 0, 0, 0, 0, 0, 0);
        // R3/R2: write in one cycle, used by the next pixel only
        pixel("R3 write pixel",       6'b000010, 0, 0, 0, 0, 1, 2'd3, 7'h03);
        pixel("R2 new colour",        6'b000010, 0, 0, 0, 0, 0, 0, 0);
        pixel("R11 sel p1",           6'b001000, 0, 0, 0, 0, 0, 0, 0);

        for (int n = 0; n < 4000; n++) begin
            logic [5:0] o;
            for (int b = 0; b < 6; b++) o[b] = ($urandom % 3) == 0;
            pixel("R11 random", o, ($urandom % 8) == 0, $urandom % 2, $urandom % 2,
                  $urandom % 2, ($urandom % 6) == 0, 2'($urandom), 7'($urandom));
        end

        rst_n = 1'b0;
        @(posedge clk);
        #2;
        compare("R1 reset again", {3'b0, sel_o, hue_o, lum_o}, 14'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) mdl[i] = 7'd0;
        pixel("R1 regs cleared", 6'b100000, 0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule